// File: doc/BRIEF.md
# Dynamic Fine Phase Step Controller

This block keeps a signed fine phase setting, counted in 1/256ths of the input clock period, and moves it by one unit each time a request is accepted. A request is one cycle of `req_en` sampled on the phase-control clock. `req_up` picks the direction. Once a step is accepted, the block waits a fixed number of settling cycles and then raises `done_o` for one cycle. Until that pulse has been given, every further request is dropped.

The usable range is set by the `lim_i` input, which gives the largest allowed magnitude of the setting. The hard bound is ±255. A step that would take the magnitude past `lim_i` without moving it closer to zero is refused. The setting stays where it is, the completion pulse still follows, and `ovf_o` reports the refusal.

Alongside the setting, the block gives the equivalent time offset in whole picoseconds, computed from a period parameter. A downstream delay line or a model uses this setting and offset.

Top module: `fine_phase_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `phase_o` equals the parameter `INIT_PHASE` clamped to the range [-`lim_i`, +`lim_i`], with `done_o` = 0 and `ovf_o` = 0.
- R2: A request is accepted on a rising clock edge where `req_en` = 1 and the controller is idle. From that edge on, `phase_o` is one greater when `req_up` = 1 and one smaller when `req_up` = 0.
- R3: For each accepted request, `done_o` is high for exactly one cycle. That cycle is the one following the `SETTLE_CYC`-th rising edge after the acceptance edge.
- R4: `req_en` is ignored from the edge after acceptance up to and including the edge that ends the `done_o` cycle. No step is made and no second completion pulse is produced.
- R5: A request whose result would have a magnitude above `lim_i` and not below the current magnitude leaves `phase_o` unchanged. It still produces the `done_o` pulse and sets `ovf_o` to 1.
- R6: `ovf_o` changes only on an acceptance edge. A step that is carried out clears it to 0.
- R7: With `lim_i` = 255, the setting reaches both +255 and -255, and a step beyond either end is refused as in R5.
- R8: `delay_ps_o` equals `phase_o` × `PERIOD_PS` / 256, truncated toward zero, as a signed integer. It follows `phase_o` without added latency.
- R9: A step that lowers the magnitude of the setting is always carried out, even when the current magnitude is above `lim_i` because the limit was lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_i | input | LIM_W | Largest allowed magnitude of the setting |
| req_en | input | 1 | Step request |
| req_up | input | 1 | Step direction: 1 = increase, 0 = decrease |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Last accepted request was refused at the limit |
| phase_o | output | LIM_W+1 | Signed current setting, in 1/256 period units |
| delay_ps_o | output | DELAY_W | Signed equivalent delay in picoseconds |

## Verification
The hardest state to reach from the ports is a setting whose magnitude is already above the limit. It can only come from a legal walk to a large value followed by a lower `lim_i`. The stimulus walks the setting through every value from +255 down to -255, then cuts `lim_i` to 10. It then checks that a step further out is refused and a step inward is taken. A second hard case is a request that lands exactly in the completion cycle. The driver holds `req_en` high across the whole pending window, through the `done_o` cycle, so that R4 is checked at its last edge.

// File: rtl/fps_pkg.sv
package fps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_REPORT = 2'd2
    } fps_state_e;

    localparam int FPS_FRAC_BITS = 8;

endpackage

// File: rtl/fps_step.sv
module fps_step #(
    parameter int LIM_W = 8
) (
    input  logic signed [LIM_W:0]   cur_i,
    input  logic                    up_i,
    input  logic [LIM_W-1:0]        lim_i,
    output logic signed [LIM_W:0]   nxt_o,
    output logic                    refuse_o
);

    localparam int WIDE_W = LIM_W + 2;

    logic signed [WIDE_W-1:0] cur_wide;
    logic signed [WIDE_W-1:0] inc_wide;
    logic signed [WIDE_W-1:0] sum_wide;
    logic [WIDE_W-1:0]        cur_mag;
    logic [WIDE_W-1:0]        sum_mag;
    logic [WIDE_W-1:0]        lim_wide;

    function automatic logic [WIDE_W-1:0] mag_of(input logic signed [WIDE_W-1:0] v);
        return v[WIDE_W-1] ? WIDE_W'(-v) : WIDE_W'(v);
    endfunction

    always_comb begin
        cur_wide = $signed({cur_i[LIM_W], cur_i});
        inc_wide = up_i ? $signed({{(WIDE_W-1){1'b0}}, 1'b1})
                        : $signed({WIDE_W{1'b1}});
        sum_wide = cur_wide + inc_wide;
        cur_mag  = mag_of(cur_wide);
        sum_mag  = mag_of(sum_wide);
        lim_wide = {2'b00, lim_i};
        refuse_o = (sum_mag > lim_wide) && (sum_mag >= cur_mag);
        nxt_o    = sum_wide[LIM_W:0];
    end

endmodule

// File: rtl/fps_delay.sv
module fps_delay #(
    parameter int LIM_W     = 8,
    parameter int PERIOD_PS = 10000,
    parameter int DELAY_W   = 16
) (
    input  logic signed [LIM_W:0]     phase_i,
    output logic signed [DELAY_W-1:0] delay_o
);

    localparam int PER_W  = $clog2(PERIOD_PS + 1);
    localparam int PROD_W = LIM_W + 1 + PER_W;

    logic              neg;
    logic [LIM_W:0]    mag;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;
    logic [PROD_W-1:0] signed_quot;

    always_comb begin
        neg         = phase_i[LIM_W];
        mag         = neg ? (LIM_W+1)'(-phase_i) : (LIM_W+1)'(phase_i);
        prod        = PROD_W'(mag) * PROD_W'(PERIOD_PS);
        quot        = prod >> fps_pkg::FPS_FRAC_BITS;
        signed_quot = neg ? (~quot + PROD_W'(1)) : quot;
        delay_o     = $signed(DELAY_W'(signed_quot));
    end

endmodule

// File: rtl/fine_phase_ctrl.sv
module fine_phase_ctrl
    import fps_pkg::*;
#(
    parameter int LIM_W      = 8,
    parameter int SETTLE_CYC = 4,
    parameter int INIT_PHASE = 0,
    parameter int PERIOD_PS  = 10000,
    parameter int DELAY_W    = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LIM_W-1:0]          lim_i,
    input  logic                      req_en,
    input  logic                      req_up,
    output logic                      done_o,
    output logic                      ovf_o,
    output logic signed [LIM_W:0]     phase_o,
    output logic signed [DELAY_W-1:0] delay_ps_o
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(SETTLE_CYC - 1);

    fps_state_e             state_q, state_d;
    logic [CNT_W-1:0]       cnt_q;
    logic                   accept;
    logic                   last_tick;
    logic signed [LIM_W:0]  phase_q;
    logic                   ovf_q;
    logic signed [LIM_W:0]  step_nxt;
    logic                   step_refuse;
    logic signed [LIM_W:0]  reset_phase;

    function automatic logic signed [LIM_W:0] clamp_init(input logic [LIM_W-1:0] lim);
        int l;
        int v;
        l = int'(lim);
        v = INIT_PHASE;
        if (v > l)  v = l;
        if (v < -l) v = -l;
        return (LIM_W+1)'(v);
    endfunction

    assign reset_phase = clamp_init(lim_i);
    assign accept      = (state_q == ST_IDLE) && req_en;
    assign last_tick   = (cnt_q == LAST_TICK);

    fps_step #(.LIM_W(LIM_W)) u_step (
        .cur_i    (phase_q),
        .up_i     (req_up),
        .lim_i    (lim_i),
        .nxt_o    (step_nxt),
        .refuse_o (step_refuse)
    );

    fps_delay #(.LIM_W(LIM_W), .PERIOD_PS(PERIOD_PS), .DELAY_W(DELAY_W)) u_delay (
        .phase_i (phase_q),
        .delay_o (delay_ps_o)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_en)    state_d = ST_SETTLE;
            ST_SETTLE: if (last_tick) state_d = ST_REPORT;
            ST_REPORT:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // State register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                cnt_q <= '0;
            else if (state_q == ST_SETTLE && !last_tick)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Phase setting and refusal flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= reset_phase;
            ovf_q   <= 1'b0;
        end else if (accept) begin
            ovf_q <= step_refuse;
            if (!step_refuse)
                phase_q <= step_nxt;
        end
    end

    // Outputs
    always_comb begin
        done_o  = (state_q == ST_REPORT);
        ovf_o   = ovf_q;
        phase_o = phase_q;
    end

endmodule

// File: rtl/fine_phase_ctrl_chk.sv
module fine_phase_ctrl_chk #(
    parameter int LIM_W      = 8,
    parameter int SETTLE_CYC = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [LIM_W-1:0]      lim_i,
    input logic                  req_en,
    input logic                  req_up,
    input logic                  done_o,
    input logic                  ovf_o,
    input logic signed [LIM_W:0] phase_o
);

    logic pend_q;
    int   wait_q;

    function automatic int mag(input logic signed [LIM_W:0] v);
        return (int'(v) < 0) ? -int'(v) : int'(v);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            wait_q <= 0;
        end else if (req_en && !pend_q) begin
            pend_q <= 1'b1;
            wait_q <= 0;
        end else if (done_o) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            wait_q <= wait_q + 1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pend_q && wait_q == SETTLE_CYC)); // R3

    AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> (mag(phase_o - $past(phase_o)) == 1)); // R2

    AST_STEP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> ((phase_o > $past(phase_o)) == $past(req_up))); // R2

    AST_NO_STEP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> $past(req_en && !pend_q)); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase_o) |-> (mag(phase_o) <= int'($past(lim_i)) ||
                               mag(phase_o) < mag($past(phase_o)))); // R5

    AST_FLAG_AT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ovf_o) |-> $past(req_en && !pend_q)); // R6

endmodule

bind fine_phase_ctrl fine_phase_ctrl_chk #(.LIM_W(LIM_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lim_i   (lim_i),
    .req_en  (req_en),
    .req_up  (req_up),
    .done_o  (done_o),
    .ovf_o   (ovf_o),
    .phase_o (phase_o)
);

// File: tb/fine_phase_ctrl_test.sv
module fine_phase_ctrl_test;

    localparam int LIM_W  = 8;
    localparam int LAT    = 4;
    localparam int INIT   = 40;
    localparam int PER_PS = 10000;
    localparam int DW     = 16;

    typedef struct {
        int phase;
        int ovf;
        int delay;
        int due;
    } exp_t;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [LIM_W-1:0]      lim_i = 8'd30;
    logic                  req_en = 1'b0;
    logic                  req_up = 1'b0;
    logic                  done_o;
    logic                  ovf_o;
    logic signed [LIM_W:0] phase_o;
    logic signed [DW-1:0]  delay_ps_o;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   m_phase = 0;
    int   m_ovf = 0;
    bit   ended = 0;
    exp_t sb[$];

    fine_phase_ctrl #(
        .LIM_W(LIM_W), .SETTLE_CYC(LAT), .INIT_PHASE(INIT),
        .PERIOD_PS(PER_PS), .DELAY_W(DW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lim_i(lim_i), .req_en(req_en), .req_up(req_up),
        .done_o(done_o), .ovf_o(ovf_o), .phase_o(phase_o), .delay_ps_o(delay_ps_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int absv(input int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: pop and compare on each completion pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(0, "R4 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(cyc == e.due, "R3 done timing", cyc, e.due);
                check(int'(phase_o) == e.phase, "R2/R5/R9 phase", int'(phase_o), e.phase);
                check(int'(ovf_o) == e.ovf, "R5/R6 ovf", int'(ovf_o), e.ovf);
                check(int'(delay_ps_o) == e.delay, "R8 delay", int'(delay_ps_o), e.delay);
            end
        end
    end

    // Driver: issue one request and push the expected outcome
    task automatic issue(input bit up, input bit intrude);
        exp_t e;
        int   nxt;
        int   acc;
        nxt = up ? m_phase + 1 : m_phase - 1;
        if (absv(nxt) > int'(lim_i) && absv(nxt) >= absv(m_phase)) begin
            m_ovf = 1;
        end else begin
            m_ovf = 0;
            m_phase = nxt;
        end
        acc = cyc + 1;
        e.phase = m_phase;
        e.ovf = m_ovf;
        e.delay = (m_phase * PER_PS) / 256;
        e.due = acc + LAT;
        sb.push_back(e);
        req_up = up;
        req_en = 1'b1;
        @(negedge clk);
        if (intrude) begin
            req_up = !up;
            repeat (LAT + 1) @(negedge clk);
        end
        req_en = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic do_reset(input int lim);
        rst_n = 1'b0;
        lim_i = LIM_W'(lim);
        repeat (2) @(negedge clk);
        begin
            int l = lim;
            int v = INIT;
            if (v > l)  v = l;
            if (v < -l) v = -l;
            m_phase = v;
            m_ovf = 0;
            check(int'(phase_o) == v, "R1 reset phase", int'(phase_o), v);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(phase_o) == m_phase, "R1 phase after release", int'(phase_o), m_phase);
        check(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
        check(ovf_o == 1'b0, "R1 ovf after reset", int'(ovf_o), 0);
        check(int'(delay_ps_o) == (m_phase * PER_PS) / 256, "R8 delay after reset",
              int'(delay_ps_o), (m_phase * PER_PS) / 256);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        @(negedge clk);
        // Clamped reset value and refusal at a narrow limit
        do_reset(30);
        issue(1'b1, 1'b0);               // R5 refused at +30
        issue(1'b0, 1'b0);               // R6 cleared by a real step
        issue(1'b0, 1'b1);               // R4 requests while pending
        repeat (3) @(negedge clk);
        check(int'(phase_o) == m_phase, "R4 phase held after pending requests",
              int'(phase_o), m_phase);
        check(done_o == 1'b0, "R4 no extra done", int'(done_o), 0);

        // Full range walk
        do_reset(255);
        while (m_phase < 255) issue(1'b1, 1'b0);
        check(int'(phase_o) == 255, "R7 top reached", int'(phase_o), 255);
        issue(1'b1, 1'b0);               // R7 refused above +255
        while (m_phase > -255) issue(1'b0, 1'b0);
        check(int'(phase_o) == -255, "R7 bottom reached", int'(phase_o), -255);
        check(int'(delay_ps_o) == (-255 * PER_PS) / 256, "R8 negative truncation",
              int'(delay_ps_o), (-255 * PER_PS) / 256);
        issue(1'b0, 1'b0);               // R7 refused below -255

        // Limit lowered beneath the current magnitude
        lim_i = 8'd10;
        @(negedge clk);
        issue(1'b0, 1'b0);               // R5 outward refused
        issue(1'b1, 1'b0);               // R9 inward accepted
        check(int'(phase_o) == -254, "R9 inward step", int'(phase_o), -254);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule